// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator

This block gathers the interrupt events of a storage-card host controller and merges them with the request of a sibling controller onto a single level-sensitive interrupt line. Event pulses from the host datapath are captured in a local status register. A local enable register decides which captured events take part in the controller's summary request. That summary, together with the sibling's request, is latched into a two-bit global status register. Two separate global masks then decide what reaches the line. The first masks which global bits are reported. The second masks which of them may drive the wire.

The block also watches the two active-low card-detect pins. It treats a card as seated only when both pins read low, and it raises the card-detect event whenever that seated/unseated state changes. The pins and two card readiness inputs pass through a synchronizer. They can be read back in an interface status word. Software reaches all of this through a simple 32-bit register port with a combinational read path.

Top module: `cfirq_top`

## Requirements
- R1: Register offsets (byte address) are: 0x00 interface status (read-only), 0x04 local status, 0x08 local enable, 0x20 global status, 0x24 global status-enable, 0x28 global signal-enable. A read returns the addressed register in the same cycle; other offsets read zero.
- R2: Local status bits 1, 2, 3, 8, 9, 10 and 11 are set by a high level on the same bit of `evt_pulse_i` at a clock edge. Bit 0 is the card-detect event. Input bits 0 and 4 to 7 are ignored, and local status bits 4 to 7 and 12 and up read zero. Local enable has the same writable bits.
- R3: A local status bit is set even while its enable bit is 0. The enable only removes the bit from the global summary.
- R4: Writing 1 to a local status bit clears it, and writing 0 leaves it unchanged.
- R5: When an event and a clearing write hit the same local status bit in the same cycle, the bit stays set.
- R6: Global status bit 0 is set one edge after any local status bit is set together with its enable bit. Global status bit 1 is set at the edge where `sib_req_i` is high. Writing 1 to a global status bit clears it.
- R7: `irq_o` is a level equal to the OR over bits 0 and 1 of (global status AND status-enable AND signal-enable).
- R8: A card counts as inserted only when both `card_det_n_i` bits are low. A change in the inserted state sets local status bit 0, after the synchronizer. A change that leaves the inserted state unchanged does nothing.
- R9: Interface status shows the synchronized `card_det_n_i[0]` at bit 2 and `card_det_n_i[1]` at bit 3, `card_rdy_i` at bit 5 and `io_rdy_i` at bit 6. All other bits read zero.
- R10: After reset all local and global registers are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| evt_pulse_i | input | 12 | Event sources, one per local status bit |
| card_det_n_i | input | 2 | Active-low card-detect pins |
| card_rdy_i | input | 1 | Card ready indication |
| io_rdy_i | input | 1 | I/O ready indication |
| sib_req_i | input | 1 | Sibling controller interrupt request |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The checker watches every cycle for three things. A source event must leave its local status bit set on the next edge, whatever clearing write arrives alongside it. A global status bit may only rise after its cause was present. The line must stay low whenever global status or the signal mask is empty. Other behaviour appears only across longer sequences, so the bench scenarios cover it. These include the exact clearing semantics of both status levels and the split between status-enable and signal-enable. They also include the inserted/removed detection through the synchronizer, the case where one detect pin alone does nothing, and the register map and read-back fields.

// File: rtl/cfirq_pkg.sv
package cfirq_pkg;
   localparam int LSTS_W = 12;
   localparam logic [LSTS_W-1:0] SRC_VALID = 12'hF0E;
   localparam logic [LSTS_W-1:0] STS_VALID = 12'hF0F;
   localparam int BIT_CARD = 0;
   localparam int GLB_W = 2;
   localparam int OFS_IFST = 'h00;
   localparam int OFS_LSTS = 'h04;
   localparam int OFS_LEN  = 'h08;
   localparam int OFS_GSTS = 'h20;
   localparam int OFS_GSEN = 'h24;
   localparam int OFS_GSIG = 'h28;
   typedef enum logic [2:0] {
      RSEL_NONE, RSEL_IFST, RSEL_LSTS, RSEL_LEN, RSEL_GSTS, RSEL_GSEN, RSEL_GSIG
   } rsel_e;
endpackage

// File: rtl/cfirq_sync.sv
module cfirq_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("cfirq_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfirq_detect.sv
module cfirq_detect (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] det_n_s_i,
   output logic       chg_o
);
   logic seated, seated_q;

   assign seated = (det_n_s_i == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seated_q <= 1'b0;
      else seated_q <= seated;
   end

   assign chg_o = seated ^ seated_q;
endmodule

// File: rtl/cfirq_local.sv
module cfirq_local #(
   parameter int W = 12,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         wr_sts_i,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] sts_o,
   output logic [W-1:0] en_o,
   output logic         pend_o
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (VALID[i]) begin : g_live
            logic sts_q, en_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sts_q <= 1'b0;
                  en_q  <= 1'b0;
               end else begin
                  sts_q <= evt_i[i] | (sts_q & ~(wr_sts_i & wdata_i[i]));
                  if (wr_en_i) en_q <= wdata_i[i];
               end
            end
            assign sts_o[i] = sts_q;
            assign en_o[i]  = en_q;
         end else begin : g_rsvd
            assign sts_o[i] = 1'b0;
            assign en_o[i]  = 1'b0;
         end
      end
   endgenerate

   assign pend_o = |(sts_o & en_o);
endmodule

// File: rtl/cfirq_global.sv
module cfirq_global #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_i,
   input  logic         wr_sts_i,
   input  logic         wr_sen_i,
   input  logic         wr_sig_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] sts_o,
   output logic [W-1:0] sen_o,
   output logic [W-1:0] sig_o,
   output logic         irq_o
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic sts_q, sen_q, sig_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sts_q <= 1'b0;
               sen_q <= 1'b0;
               sig_q <= 1'b0;
            end else begin
               sts_q <= req_i[i] | (sts_q & ~(wr_sts_i & wdata_i[i]));
               if (wr_sen_i) sen_q <= wdata_i[i];
               if (wr_sig_i) sig_q <= wdata_i[i];
            end
         end
         assign sts_o[i] = sts_q;
         assign sen_o[i] = sen_q;
         assign sig_o[i] = sig_q;
      end
   endgenerate

   assign irq_o = |(sts_o & sen_o & sig_o);
endmodule

// File: rtl/cfirq_top.sv
module cfirq_top
   import cfirq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LSTS_W-1:0] evt_pulse_i,
   input  logic [1:0]        card_det_n_i,
   input  logic              card_rdy_i,
   input  logic              io_rdy_i,
   input  logic              sib_req_i,
   output logic              irq_o
);
   localparam int PIN_W = 4;

   generate
      if (DATA_W < LSTS_W) begin : g_bad_dw
         $error("cfirq_top: DATA_W too narrow for local status");
      end
      if (ADDR_W < 6) begin : g_bad_aw
         $error("cfirq_top: ADDR_W too narrow for register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cfirq_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   logic             card_chg;
   logic [LSTS_W-1:0] lsts, len, levt;
   logic              lpend;
   logic [GLB_W-1:0]  gsts, gsen, gsig;
   rsel_e             rsel;
   logic              wr;

   cfirq_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({io_rdy_i, card_rdy_i, card_det_n_i}),
      .q_o(pins_s)
   );

   cfirq_detect u_det (
      .clk(clk), .rst_n(rst_n),
      .det_n_s_i(pins_s[1:0]),
      .chg_o(card_chg)
   );

   always_comb begin
      levt = evt_pulse_i & SRC_VALID;
      levt[BIT_CARD] = card_chg;
   end

   always_comb begin
      rsel = RSEL_NONE;
      if (bus_addr == ADDR_W'(OFS_IFST)) rsel = RSEL_IFST;
      else if (bus_addr == ADDR_W'(OFS_LSTS)) rsel = RSEL_LSTS;
      else if (bus_addr == ADDR_W'(OFS_LEN))  rsel = RSEL_LEN;
      else if (bus_addr == ADDR_W'(OFS_GSTS)) rsel = RSEL_GSTS;
      else if (bus_addr == ADDR_W'(OFS_GSEN)) rsel = RSEL_GSEN;
      else if (bus_addr == ADDR_W'(OFS_GSIG)) rsel = RSEL_GSIG;
   end

   assign wr = bus_req & bus_wr;

   cfirq_local #(.W(LSTS_W), .VALID(STS_VALID)) u_loc (
      .clk(clk), .rst_n(rst_n),
      .evt_i(levt),
      .wr_sts_i(wr && rsel == RSEL_LSTS),
      .wr_en_i(wr && rsel == RSEL_LEN),
      .wdata_i(bus_wdata[LSTS_W-1:0]),
      .sts_o(lsts), .en_o(len), .pend_o(lpend)
   );

   cfirq_global #(.W(GLB_W)) u_glb (
      .clk(clk), .rst_n(rst_n),
      .req_i({sib_req_i, lpend}),
      .wr_sts_i(wr && rsel == RSEL_GSTS),
      .wr_sen_i(wr && rsel == RSEL_GSEN),
      .wr_sig_i(wr && rsel == RSEL_GSIG),
      .wdata_i(bus_wdata[GLB_W-1:0]),
      .sts_o(gsts), .sen_o(gsen), .sig_o(gsig),
      .irq_o(irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (rsel)
         RSEL_IFST: begin
            bus_rdata[2] = pins_s[0];
            bus_rdata[3] = pins_s[1];
            bus_rdata[5] = pins_s[2];
            bus_rdata[6] = pins_s[3];
         end
         RSEL_LSTS: bus_rdata[LSTS_W-1:0] = lsts;
         RSEL_LEN:  bus_rdata[LSTS_W-1:0] = len;
         RSEL_GSTS: bus_rdata[GLB_W-1:0]  = gsts;
         RSEL_GSEN: bus_rdata[GLB_W-1:0]  = gsen;
         RSEL_GSIG: bus_rdata[GLB_W-1:0]  = gsig;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cfirq_chk.sv
module cfirq_chk
   import cfirq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [LSTS_W-1:0] evt_pulse_i,
   input logic              sib_req_i,
   input logic              irq_o,
   input logic [LSTS_W-1:0] lsts,
   input logic [LSTS_W-1:0] len,
   input logic [GLB_W-1:0]  gsts,
   input logic [GLB_W-1:0]  gsig
);
   // R3 R5
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse_i & SRC_VALID)) |=>
         ((lsts & $past(evt_pulse_i & SRC_VALID)) == $past(evt_pulse_i & SRC_VALID)));

   // R6
   gbit0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gsts[0]) |-> $past(|(lsts & len)));

   // R6
   gbit1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gsts[1]) |-> $past(sib_req_i));

   // R7
   irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gsts == '0) |-> !irq_o);

   // R7
   irq_needs_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gsig == '0) |-> !irq_o);
endmodule

bind cfirq_top cfirq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt_pulse_i), .sib_req_i(sib_req_i),
   .irq_o(irq_o), .lsts(lsts), .len(len), .gsts(gsts), .gsig(gsig)
);

// File: tb/cfirq_top_tb.sv
`timescale 1ns/1ps
module cfirq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [11:0] evt_pulse_i = '0;
   logic [1:0]  card_det_n_i = 2'b11;
   logic        card_rdy_i = 1'b0, io_rdy_i = 1'b0, sib_req_i = 1'b0;
   logic        irq_o;
   int          errors = 0, checks = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   cfirq_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_pulse_i(evt_pulse_i), .card_det_n_i(card_det_n_i),
      .card_rdy_i(card_rdy_i), .io_rdy_i(io_rdy_i), .sib_req_i(sib_req_i),
      .irq_o(irq_o)
   );

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (bus_req && !bus_wr && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
         end
      end
   end

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1;
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_req = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] v);
      @(posedge clk); #1;
      evt_pulse_i = v;
      @(posedge clk); #1;
      evt_pulse_i = '0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (irq_o !== e) begin
         errors++;
         $display("FAIL %s: irq_o=%b expected=%b", t, irq_o, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      // R10 reset state
      rd_exp(6'h04, 32'h0, "R10 local status");
      rd_exp(6'h08, 32'h0, "R10 local enable");
      rd_exp(6'h20, 32'h0, "R10 global status");
      chk_irq(1'b0, "R10 irq");
      // R9 pins high, ready low
      rd_exp(6'h00, 32'h0000_000C, "R9 iface reset");
      // R1 unmapped offset
      rd_exp(6'h10, 32'h0, "R1 unmapped");

      // R3 disabled event still latched, no global contribution
      pulse(12'h400);
      idle(2);
      rd_exp(6'h04, 32'h400, "R3 latch while disabled");
      rd_exp(6'h20, 32'h0, "R3 no global");
      // R4 write zero keeps, write one clears
      wr_reg(6'h04, 32'h0);
      rd_exp(6'h04, 32'h400, "R4 write zero");
      wr_reg(6'h04, 32'h400);
      rd_exp(6'h04, 32'h0, "R4 write one");

      // R2 ignored inputs and reserved bits
      pulse(12'h0F1);
      idle(2);
      rd_exp(6'h04, 32'h0, "R2 ignored sources");
      pulse(12'h30E);
      idle(1);
      rd_exp(6'h04, 32'h30E, "R2 source positions");
      wr_reg(6'h04, 32'hFFFF_FFFF);
      wr_reg(6'h08, 32'hFFFF_FFFF);
      rd_exp(6'h08, 32'h0F0F, "R2 enable mask");
      wr_reg(6'h08, 32'h0);
      idle(2);
      wr_reg(6'h20, 32'h3);

      // R6 R7 enabled event reaches global and line
      wr_reg(6'h08, 32'h800);
      pulse(12'h800);
      idle(2);
      rd_exp(6'h20, 32'h1, "R6 global bit0");
      chk_irq(1'b0, "R7 no masks");
      wr_reg(6'h24, 32'h1);
      chk_irq(1'b0, "R7 status-enable only");
      wr_reg(6'h28, 32'h1);
      chk_irq(1'b1, "R7 both masks");
      wr_reg(6'h04, 32'h800);
      idle(1);
      wr_reg(6'h20, 32'h1);
      idle(1);
      rd_exp(6'h20, 32'h0, "R6 global clear");
      chk_irq(1'b0, "R7 line drops");

      // R6 R7 sibling
      @(posedge clk); #1 sib_req_i = 1'b1;
      @(posedge clk); #1 sib_req_i = 1'b0;
      rd_exp(6'h20, 32'h2, "R6 sibling bit");
      wr_reg(6'h24, 32'h3);
      chk_irq(1'b0, "R7 sibling signal masked");
      wr_reg(6'h28, 32'h3);
      chk_irq(1'b1, "R7 sibling signal open");
      wr_reg(6'h20, 32'h2);
      chk_irq(1'b0, "R6 sibling clear");
      rd_exp(6'h28, 32'h3, "R1 signal-enable readback");

      // R5 event and clear in same cycle
      @(posedge clk); #1;
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h200;
      evt_pulse_i = 12'h200;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_wr = 1'b0; evt_pulse_i = '0;
      rd_exp(6'h04, 32'h200, "R5 event beats clear");
      wr_reg(6'h04, 32'h200);

      // R8 partial insertion does nothing
      card_det_n_i = 2'b10;
      idle(6);
      rd_exp(6'h04, 32'h0, "R8 one pin low");
      rd_exp(6'h00, 32'h8, "R9 pin0 low");
      card_det_n_i = 2'b00;
      idle(6);
      rd_exp(6'h04, 32'h1, "R8 insertion");
      wr_reg(6'h04, 32'h1);
      card_det_n_i = 2'b01;
      idle(6);
      rd_exp(6'h04, 32'h1, "R8 removal");
      wr_reg(6'h04, 32'h1);

      // R9 ready bits
      card_det_n_i = 2'b11;
      card_rdy_i = 1'b1; io_rdy_i = 1'b1;
      idle(6);
      rd_exp(6'h00, 32'h6C, "R9 ready bits");

      idle(3);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule